// File: doc/BRIEF.md
# Up-Down PWM Phase Clock Generator

This block builds a symmetric triangle-wave time base from a fast PWM clock and derives a phase clock from it. A signed counter climbs from the negative extreme to the positive extreme and then falls back. Each extreme is held for one extra cycle at the turn. Every direction of travel therefore lasts 2N+3 clocks and a full PWM cycle lasts 4N+6 clocks, where N is a 15-bit programmable limit. At each turn the block emits a one-cycle max-phase strobe, so that strobe runs at twice the PWM frequency. At the bottom turn it also emits a PWM-period strobe.

A host writes a new limit at any time. The value waits in a shadow register and takes effect only at the next bottom turn, so no PWM cycle mixes two limits. A 4-bit divider ratio M thins the max-phase strobes down to a phase strobe. A single compare input drives a center-aligned PWM output as a check that the time base works. With the reset limit of 6527 and a 117.9648 MHz clock, the max-phase rate is about 9.03 kHz and the PWM rate is about 4.52 kHz.

Top module: `updown_phase_clock`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, the limit is 6527, `tri_cnt` is -6528, `cnt_up` is 1, and all three strobes are 0.
- R2: Outside a turn, `tri_cnt` moves by exactly one per clock in the direction `cnt_up` gives, and it always stays within -(N+1) to N+1 of the active limit N.
- R3: After `tri_cnt` reaches N+1 while rising, the next cycle keeps `tri_cnt` at N+1, shows `cnt_up`=0 and has `maxph_stb`=1. `maxph_stb` is high exactly in the cycles where `cnt_up` has just changed.
- R4: After `tri_cnt` reaches -(N+1) while falling, the next cycle shows `cnt_up`=1 with `maxph_stb`=1 and `pwm_stb`=1, and `tri_cnt` equals -(N'+1) for the limit N' now in force.
- R5: Max-phase strobes are 2N+3 cycles apart and PWM-period strobes are 4N+6 cycles apart. After reset, the first max-phase strobe comes in cycle 13057 and the first PWM-period strobe in cycle 26114.
- R6: A cycle with `lim_wr`=1 stores `lim_data` as the pending limit. The active limit changes only at a bottom turn, where it takes the pending value. A write made in the same cycle as a bottom turn applies at the following bottom turn.
- R7: `phase_stb` is high only together with `maxph_stb`, on every (M+1)th max-phase strobe counted from reset, where M is `ph_div`.
- R8: `pwm_out` is 1 when `cmp_val` is at or above N+1 and 0 when `cmp_val` is at or below -(N+1). Otherwise it is 1 exactly when `tri_cnt` < `cmp_val`. The output is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PWM clock |
| rst | input | 1 | Synchronous reset, active high |
| lim_wr | input | 1 | Write strobe for the pending limit |
| lim_data | input | 15 | New limit value N |
| ph_div | input | 4 | Phase divider ratio M (the phase strobe fires on every M+1 max-phase strobes) |
| cmp_val | input | 17 | Signed compare value for the PWM output |
| tri_cnt | output | 17 | Signed triangle count |
| cnt_up | output | 1 | 1 while the count is rising |
| maxph_stb | output | 1 | One-cycle strobe at every turn |
| pwm_stb | output | 1 | One-cycle strobe at every bottom turn |
| phase_stb | output | 1 | Divided max-phase strobe |
| pwm_out | output | 1 | Center-aligned PWM output |

## Verification
The assertions check several rules on every cycle. They check the unit step between turns and the count range against the live limit. They check that the max-phase strobe matches the direction change, that the count holds at the top turn, and that the limit changes only at a bottom turn. They also check that the phase strobe never comes without a max-phase strobe and that the compare output is saturated beyond the extremes.

Other behaviour needs the bench scenarios. These include the exact 2N+3 and 4N+6 spacing after reset and the deferral of a written limit by one full period. They also include the (M+1) cadence of the phase strobe for several ratios and the compare result in the interior, checked across many limits and compare values.

// File: rtl/updown_phase_clock.sv
module updown_phase_clock #(
  parameter int LW = 15,
  parameter int DW = 4,
  parameter logic [LW-1:0] RST_LIM = 15'd6527,
  localparam int CW = LW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lim_wr,
  input  logic [LW-1:0]        lim_data,
  input  logic [DW-1:0]        ph_div,
  input  logic signed [CW-1:0] cmp_val,
  output logic signed [CW-1:0] tri_cnt,
  output logic                 cnt_up,
  output logic                 maxph_stb,
  output logic                 pwm_stb,
  output logic                 phase_stb,
  output logic                 pwm_out
);

  logic [LW-1:0] lim, shadow;
  logic [DW-1:0] div_cnt;
  logic signed [CW-1:0] ext, nxt_ext, rst_ext;

  assign ext     = $signed({2'b00, lim}) + CW'(1);
  assign nxt_ext = $signed({2'b00, shadow}) + CW'(1);
  assign rst_ext = $signed({2'b00, RST_LIM}) + CW'(1);

  logic at_top, at_bot, turn;
  assign at_top = cnt_up && (tri_cnt == ext);
  assign at_bot = !cnt_up && (tri_cnt == -ext);
  assign turn   = at_top || at_bot;

  assign pwm_out = (cmp_val >= ext)  ? 1'b1 :
                   (cmp_val <= -ext) ? 1'b0 :
                   (tri_cnt < cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      tri_cnt   <= -rst_ext;
      cnt_up    <= 1'b1;
      lim       <= RST_LIM;
      shadow    <= RST_LIM;
      maxph_stb <= 1'b0;
      pwm_stb   <= 1'b0;
    end else begin
      if (lim_wr) shadow <= lim_data;
      maxph_stb <= turn;
      pwm_stb   <= at_bot;
      if (at_top) begin
        cnt_up <= 1'b0;
      end else if (at_bot) begin
        cnt_up  <= 1'b1;
        lim     <= shadow;
        tri_cnt <= -nxt_ext;
      end else if (cnt_up) begin
        tri_cnt <= tri_cnt + CW'(1);
      end else begin
        tri_cnt <= tri_cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      phase_stb <= 1'b0;
    end else if (turn) begin
      if (div_cnt >= ph_div) begin
        div_cnt   <= '0;
        phase_stb <= 1'b1;
      end else begin
        div_cnt   <= div_cnt + DW'(1);
        phase_stb <= 1'b0;
      end
    end else begin
      phase_stb <= 1'b0;
    end
  end

endmodule

// File: rtl/updown_phase_clock_chk.sv
module updown_phase_clock_chk #(
  parameter int LW = 15,
  localparam int CW = LW + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [LW-1:0]        lim,
  input logic signed [CW-1:0] cmp_val,
  input logic signed [CW-1:0] tri_cnt,
  input logic                 cnt_up,
  input logic                 maxph_stb,
  input logic                 pwm_stb,
  input logic                 phase_stb,
  input logic                 pwm_out
);

  logic signed [CW-1:0] e;
  assign e = $signed({2'b00, lim}) + CW'(1);

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !maxph_stb) |-> (tri_cnt == (cnt_up ? $past(tri_cnt) + CW'(1) : $past(tri_cnt) - CW'(1)))); // R2
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (tri_cnt <= e) && (tri_cnt >= -e)); // R2
  AST_STB_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (maxph_stb == (cnt_up != $past(cnt_up)))); // R3
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (maxph_stb && !cnt_up) |-> (tri_cnt == $past(tri_cnt))); // R3
  AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst)
    pwm_stb |-> (maxph_stb && cnt_up && tri_cnt == -e)); // R4
  AST_LIM_AT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    !pwm_stb |-> $stable(lim)); // R6
  AST_PHASE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    phase_stb |-> maxph_stb); // R7
  AST_CMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cmp_val >= e) |-> pwm_out); // R8
  AST_CMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmp_val <= -e) |-> !pwm_out); // R8

endmodule

bind updown_phase_clock updown_phase_clock_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .lim(lim), .cmp_val(cmp_val), .tri_cnt(tri_cnt),
  .cnt_up(cnt_up), .maxph_stb(maxph_stb), .pwm_stb(pwm_stb),
  .phase_stb(phase_stb), .pwm_out(pwm_out)
);

// File: tb/sim_updown_phase_clock.sv
module sim_updown_phase_clock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lim_wr = 1'b0;
  logic [14:0] lim_data = '0;
  logic [3:0] ph_div = '0;
  logic signed [16:0] cmp_val = '0;
  logic signed [16:0] tri_cnt;
  logic cnt_up, maxph_stb, pwm_stb, phase_stb, pwm_out;

  always #2 clk = ~clk;

  updown_phase_clock u0 (
    .clk(clk), .rst(rst), .lim_wr(lim_wr), .lim_data(lim_data), .ph_div(ph_div),
    .cmp_val(cmp_val), .tri_cnt(tri_cnt), .cnt_up(cnt_up), .maxph_stb(maxph_stb),
    .pwm_stb(pwm_stb), .phase_stb(phase_stb), .pwm_out(pwm_out)
  );

  int nchk = 0, nerr = 0;
  int t, seg_s, seg_n, pend, k, m, idx;
  bit fin;
  int ns [10] = '{0, 0, 1, 1, 2, 5, 5, 3, 0, 4};

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", r, act, exp, t);
    end
  endtask

  task automatic cycle_check();
    int d, per, h, p, ec, cv;
    bit eu, emp, epw, eph, epo;
    d = t - seg_s; per = 4*seg_n + 6; h = 2*seg_n + 3; p = d % per;
    ec  = (p < h) ? -(seg_n+1) + p : (seg_n+1) - (p - h);
    eu  = (p < h);
    emp = (t != 0) && (p % h == 0);
    epw = (t != 0) && (p == 0);
    if (emp) k++;
    eph = emp && (k % (m+1) == 0);
    cv  = ((t*7) % (2*seg_n + 9)) - (seg_n + 4);
    cmp_val = 17'(cv);
    #1;
    epo = (cv >= seg_n+1) ? 1'b1 : (cv <= -(seg_n+1)) ? 1'b0 : (ec < cv);
    chk("R2 count", int'(tri_cnt), ec);
    chk("R3 direction", int'(cnt_up), int'(eu));
    chk("R5 max-phase strobe", int'(maxph_stb), int'(emp));
    chk("R4 pwm-period strobe", int'(pwm_stb), int'(epw));
    chk("R7 phase strobe", int'(phase_stb), int'(eph));
    chk("R8 pwm output", int'(pwm_out), int'(epo));
  endtask

  task automatic run_cfg(int mv);
    rst = 1'b1; ph_div = 4'(mv); m = mv; lim_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t = 0; k = 0; seg_s = 0; seg_n = 6527; pend = 6527; idx = 0; fin = 0;
    chk("R1 reset count", int'(tri_cnt), -6528);
    chk("R1 reset direction", int'(cnt_up), 1);
    chk("R1 reset strobes", int'({maxph_stb, pwm_stb, phase_stb}), 0);
    forever begin
      if (t > 0 && t == seg_s + 4*seg_n + 6) begin
        seg_s = t; seg_n = pend;
        chk("R6 new limit at bottom", int'(tri_cnt), -(seg_n+1));
      end
      if (t == seg_s) begin
        if (idx < 10) begin
          pend = ns[idx]; idx++;
          lim_wr = 1'b1; lim_data = 15'(pend);
        end else if (fin) break;
        else fin = 1;
      end
      if (t == 13057) chk("R5 first max-phase strobe", int'(maxph_stb), 1);
      if (t == 26114) chk("R5 first pwm-period strobe", int'(pwm_stb), 1);
      cycle_check();
      @(posedge clk); @(negedge clk);
      lim_wr = 1'b0;
      t++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    run_cfg(0);
    run_cfg(2);
    run_cfg(15);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule